// File: doc/BRIEF.md
# Power and Clock Control Unit

This block manages power for a small 8-bit microcontroller core. Software reads and writes it through an 8-bit control register. From the oscillator clock it makes two clock-enable outputs, one for the CPU and one for the peripherals (RAM, timers, serial port and interrupt logic). Both enables follow a divide-by-two phase, unless double-speed mode is selected. In that case they can be high on every oscillator cycle.

Software writes a mode bit to enter idle, which stops only the CPU enable, or power-down, which stops both enables. Idle ends on an external interrupt or a warm reset. Power-down ends on an external interrupt, on the reset pin going high, or on a brownout strobe. A wake counter then holds the CPU enable low for a set number of oscillator cycles. The block also holds a cold-start flag. Only the asynchronous power-on reset sets this flag. Warm resets leave it alone.

Control register bits, from bit 7 down to bit 0: baud-double, frame-error select, PWM enable, cold-start flag, general flag 1, general flag 0, power-down, idle.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After the power-on reset (`por_n` low), the register reads 8'h10. The cold-start flag (bit 4) is 1 and all other bits are 0. The unit is in run mode.
- R2: With `x2_mode` = 0, `per_en` (and `cpu_en` in run mode) is high on exactly every other oscillator cycle. With `x2_mode` = 1, it is high on every cycle.
- R3: In run mode, a write with bits 1:0 = 0 stores bits 7:2 as written, and they read back unchanged. These bits do not affect `cpu_en` or `per_en`.
- R4: Writing bit 0 = 1 (idle) with bit 1 = 0 drops `cpu_en` from the next cycle. `per_en` keeps running, and bit 0 reads 1.
- R5: Writing bit 1 = 1 (power-down) drops both `cpu_en` and `per_en` from the next cycle. Power-down wins over idle: bit 1 reads 1 and bit 0 reads 0, even if both bits were written as 1.
- R6: `ext_int` in idle returns the unit to run mode on the next cycle and clears bit 0. In run mode, `ext_int` has no effect.
- R7: `ext_int` in power-down starts the wake period and clears bit 1. `per_en` resumes at once. `cpu_en` stays low for exactly WAKE_CYCLES oscillator cycles and then follows the clock phase again.
- R8: `rst_pin` going high in power-down starts the same wake period. `cpu_rst` is high for as long as `rst_pin` (or `bod_rst`) is high, including after the wake period has ended.
- R9: While `rst_pin` or `bod_rst` is high, every bit except bit 4 is cleared, and register writes are ignored. A warm reset during idle returns the unit to run mode.
- R10: Software can set and clear the cold-start flag (bit 4). A warm reset through either `rst_pin` or `bod_rst` never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous cold power-on reset, active low |
| x2_mode | input | 1 | 1 bypasses the divide-by-two |
| rst_pin | input | 1 | External reset pin, active high, synchronous |
| bod_rst | input | 1 | Brownout warm-reset strobe |
| ext_int | input | 1 | External interrupt wake request |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| cpu_en | output | 1 | CPU clock enable |
| per_en | output | 1 | Peripheral clock enable |
| cpu_rst | output | 1 | CPU reset request |

## Verification
The register is swept with all 256 write values, with the mode bits masked off. This separates correct storage of every bit from any side effect on the enables. Idle and power-down are entered with several different upper-bit patterns. Power-down is also entered with both mode bits set, which exposes the priority rule. Wake-up is driven once by interrupt and once by the reset pin. In both cases `cpu_en` is checked on every cycle of the wake window, which catches a counter that is one cycle off. Warm resets from the pin and from the brownout strobe are applied with the cold-start flag both set and clear. This separates clearing of the other bits from any disturbance of the flag.

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl #(
  parameter int WAKE_CYCLES = 48000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       x2_mode,
  input  logic       rst_pin,
  input  logic       bod_rst,
  input  logic       ext_int,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_en,
  output logic       per_en,
  output logic       cpu_rst
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  typedef enum logic [1:0] {M_RUN, M_IDLE, M_PD, M_WAKE} mode_t;

  mode_t         mode;
  logic [7:0]    ctl;
  logic [CW-1:0] wcnt;
  logic          div_ph;

  wire warm    = rst_pin | bod_rst;
  wire wr_ok   = reg_wr & (mode == M_RUN) & ~warm;
  wire base_en = x2_mode | div_ph;

  assign reg_rdata = ctl;
  assign cpu_en    = base_en & (mode == M_RUN);
  assign per_en    = base_en & (mode != M_PD);
  assign cpu_rst   = warm;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl    <= 8'h10;
      mode   <= M_RUN;
      wcnt   <= '0;
      div_ph <= 1'b0;
    end else begin
      div_ph <= ~div_ph;
      case (mode)
        M_RUN:
          if (wr_ok) begin
            ctl  <= {reg_wdata[7:1], reg_wdata[0] & ~reg_wdata[1]};
            mode <= reg_wdata[1] ? M_PD : (reg_wdata[0] ? M_IDLE : M_RUN);
          end
        M_IDLE:
          if (warm | ext_int) begin
            ctl[0] <= 1'b0;
            mode   <= M_RUN;
          end
        M_PD:
          if (warm | ext_int) begin
            ctl[1] <= 1'b0;
            wcnt   <= '0;
            mode   <= M_WAKE;
          end
        default:
          if (wcnt == LAST) mode <= M_RUN;
          else wcnt <= wcnt + 1'b1;
      endcase
      if (warm) ctl <= {3'b000, ctl[4], 4'b0000};
    end
  end

  // R5
  pd_gates_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[1] |-> (!cpu_en && !per_en && !reg_rdata[0]));

  // R4
  idle_stops_cpu_chk: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[0] |-> !cpu_en);

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (per_en && !x2_mode) |=> (!per_en || x2_mode));

  // R10
  pof_warm_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm |=> $stable(reg_rdata[4]));

  // R9
  warm_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    warm |=> (reg_rdata[7:5] == 3'b000 && reg_rdata[3:0] == 4'b0000));

  // R3
  gp_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (reg_wr && !warm && mode == M_RUN) |=> reg_rdata[3:2] == $past(reg_wdata[3:2]));
endmodule

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
  localparam int W = 5;

  logic clk = 1'b0;
  logic por_n, x2_mode, rst_pin, bod_rst, ext_int, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic cpu_en, per_en, cpu_rst;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pwr_clk_ctrl #(.WAKE_CYCLES(W)) u0 (
    .clk(clk), .por_n(por_n), .x2_mode(x2_mode), .rst_pin(rst_pin),
    .bod_rst(bod_rst), .ext_int(ext_int), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_en(cpu_en),
    .per_en(per_en), .cpu_rst(cpu_rst));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    por_n = 1'b0; x2_mode = 1'b1; rst_pin = 1'b0; bod_rst = 1'b0;
    ext_int = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    step();
    // R1
    chk("R1 reg", reg_rdata, 8'h10);
    chk("R1 cpu_en", cpu_en, 1);

    // R2 divider
    x2_mode = 1'b0;
    step();
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      int prev;
      prev = per_en;
      step();
      cnt += per_en;
      chk("R2 alternate", per_en, prev ^ 1);
      chk("R2 cpu follows per", cpu_en, per_en);
    end
    chk("R2 half count", cnt, 4);
    x2_mode = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      cnt += cpu_en;
    end
    chk("R2 full count", cnt, 8);

    // R3 exhaustive write sweep
    for (int v = 0; v < 256; v++) begin
      wr(8'(v) & 8'hFC);
      chk("R3 readback", reg_rdata, v & 8'hFC);
      chk("R3 cpu_en", cpu_en, 1);
    end

    // R4 / R6 idle with several upper patterns
    for (int v = 0; v < 4; v++) begin
      logic [7:0] base;
      base = 8'(v * 8'h44) & 8'hFC;
      wr(base | 8'h01);
      chk("R4 reg", reg_rdata, base | 8'h01);
      chk("R4 cpu_en", cpu_en, 0);
      chk("R4 per_en", per_en, 1);
      step();
      chk("R4 cpu_en held", cpu_en, 0);
      ext_int = 1'b1;
      step();
      ext_int = 1'b0;
      chk("R6 cpu_en back", cpu_en, 1);
      chk("R6 reg", reg_rdata, base);
    end
    wr(8'h2C);
    ext_int = 1'b1;
    step();
    ext_int = 1'b0;
    chk("R6 run ignore reg", reg_rdata, 8'h2C);
    chk("R6 run ignore cpu", cpu_en, 1);

    // R5 / R7 power-down, both bits written, interrupt wake
    wr(8'hA3);
    chk("R5 priority", reg_rdata, 8'hA2);
    chk("R5 cpu_en", cpu_en, 0);
    chk("R5 per_en", per_en, 0);
    step();
    chk("R5 per_en held", per_en, 0);
    ext_int = 1'b1;
    for (int k = 1; k <= W + 1; k++) begin
      step();
      ext_int = 1'b0;
      chk("R7 wake cpu_en", cpu_en, (k == W + 1) ? 1 : 0);
      chk("R7 wake per_en", per_en, 1);
    end
    chk("R7 reg", reg_rdata, 8'hA0);

    // R8 reset-pin wake
    wr(8'h12);
    chk("R8 pd entered", per_en, 0);
    rst_pin = 1'b1;
    for (int k = 1; k <= W + 1; k++) begin
      step();
      chk("R8 wake cpu_en", cpu_en, (k == W + 1) ? 1 : 0);
      chk("R8 cpu_rst", cpu_rst, 1);
    end
    chk("R8 reg", reg_rdata, 8'h10);
    step();
    chk("R8 cpu_rst held", cpu_rst, 1);
    rst_pin = 1'b0;
    step();
    chk("R8 cpu_rst release", cpu_rst, 0);

    // R9 writes ignored during reset, reset exits idle, brownout clears
    rst_pin = 1'b1;
    wr(8'hEC);
    chk("R9 write ignored", reg_rdata, 8'h10);
    rst_pin = 1'b0;
    wr(8'h45);
    chk("R9 idle entered", cpu_en, 0);
    rst_pin = 1'b1;
    step();
    rst_pin = 1'b0;
    chk("R9 idle exit", cpu_en, 1);
    chk("R9 idle reg", reg_rdata, 8'h00);
    wr(8'hEC);
    bod_rst = 1'b1;
    step();
    bod_rst = 1'b0;
    chk("R9 bod clear", reg_rdata, 8'h00);

    // R10 cold-start flag under software and warm resets
    wr(8'hFC);
    chk("R10 set", reg_rdata, 8'hFC);
    rst_pin = 1'b1;
    step();
    rst_pin = 1'b0;
    chk("R10 pin keeps 1", reg_rdata, 8'h10);
    bod_rst = 1'b1;
    step();
    bod_rst = 1'b0;
    chk("R10 bod keeps 1", reg_rdata, 8'h10);
    wr(8'h00);
    rst_pin = 1'b1;
    step();
    rst_pin = 1'b0;
    chk("R10 pin keeps 0", reg_rdata, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule